// File: doc/BRIEF.md
# Adjustable-rate PTP time counter

This block keeps a free-running nanosecond time value for IEEE 1588 timestamping. On each enabled reference clock cycle it adds a programmable increment to the count. To trim the rate in parts per billion, a second increment can replace the normal one on one cycle out of every N. The value N sits in its own register, and N equal to zero turns the trimming off.

The count can fold back at a programmable period instead of the full 32-bit width. A period of 2^31 gives a 31-bit timer. Whenever the count folds, a one-cycle wrap pulse goes out to the compare channels, and the live count goes out with it. Software works the block through a simple register port. It can start and stop counting, clear the count, latch a snapshot for reading, and load a new time value directly.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the count, the snapshot, the control bits, every configuration register and the wrap pulse are all zero.
- R2: While enable (bit 0 of the control register at 0x400) is set, each clock adds the normal increment (bits 6:0 of the register at 0x414) to the count, which time_now shows one cycle later. While enable is clear, the count holds.
- R3: With a correction period N (register 0x410) of at least 1, every Nth enabled cycle adds the correction increment (bits 14:8 of 0x414) in place of the normal one. N = 1 corrects on every cycle, and N = 0 never corrects.
- R4: With period folding on (control bit 4) and a nonzero period (register 0x40C), a sum at or above the period is reduced by the period, so any excess is carried into the new count, and wrap_pulse is high for exactly the following cycle. Otherwise the count wraps modulo 2^32 and wrap_pulse stays low.
- R5: Writing control bit 11 latches the count held before that edge into the snapshot. From the next cycle, reading 0x404 returns the snapshot. The bit reads back as 0.
- R6: A write to 0x404 loads the written value into the count and takes precedence over counting in that cycle.
- R7: Writing control bit 9 clears the count and the correction phase, and takes precedence over a load. It leaves the increment, period and correction period registers unchanged, and the bit reads back as 0.
- R8: Control bits 0, 4 and 13 (bit 13 selects slave mode) read back as written. Registers 0x40C, 0x410 and 0x414 read back their fields, with 0x414 returning the normal increment in bits 6:0 and the correction increment in bits 14:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| time_now | output | 32 | Live count |
| wrap_pulse | output | 1 | One-cycle pulse after a period fold |

## Verification
Directed sequences use hand-computed values for several cases:
- a 4/4/6 correction pattern with N = 3, which shows the correction landing on the third cycle and not on the first;
- N = 1, which separates correcting on every cycle from correcting on none;
- a load of 95 with increment 10 and period 100, which must give 5, so excess carry is told apart from a clear to zero;
- a value just below 2^32, which must wrap without a pulse.

Seeded random traffic then mixes register writes, loads, restarts, captures and reads. Every cycle is compared against a bench model, which separates the precedence of restart over load over counting and shows stale snapshots.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  parameter int CNT_W  = 32;
  parameter int INC_W  = 7;
  parameter int ADDR_W = 12;
  parameter int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] A_TIME   = ADDR_W'(12'h404);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(12'h40C);
  localparam logic [ADDR_W-1:0] A_CPER   = ADDR_W'(12'h410);
  localparam logic [ADDR_W-1:0] A_INC    = ADDR_W'(12'h414);

  localparam int B_EN   = 0;
  localparam int B_FOLD = 4;
  localparam int B_RST  = 9;
  localparam int B_CAP  = 11;
  localparam int B_SLV  = 13;
  localparam int INC_LO  = 0;
  localparam int CINC_LO = 8;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [INC_W-1:0] inc_t;

  typedef struct packed {
    logic en;
    logic fold;
    logic slave;
    inc_t inc;
    inc_t cinc;
    cnt_t period;
    cnt_t cper;
  } cfg_t;

  typedef struct packed {
    cnt_t val;
    logic wrapped;
  } step_t;

  // One count step: add, then fold at the period when enabled.
  function automatic step_t advance(cnt_t cur, inc_t add, logic fold, cnt_t period);
    step_t r;
    logic [CNT_W:0] sum;
    sum = {1'b0, cur} + {{(CNT_W + 1 - INC_W){1'b0}}, add};
    if (fold && (period != '0) && (sum >= {1'b0, period})) begin
      r.val     = CNT_W'(sum - {1'b0, period});
      r.wrapped = 1'b1;
    end else begin
      r.val     = sum[CNT_W-1:0];
      r.wrapped = 1'b0;
    end
    return r;
  endfunction

  // Correction is due when the phase has reached the last cycle of the window.
  function automatic logic corr_due(cnt_t phase, cnt_t cper);
    return (cper != '0) && (phase >= cper - 1'b1);
  endfunction
endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
  import ptp_tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  cnt_t              snapshot,
  output cfg_t              cfg,
  output logic              restart_req,
  output logic              capture_req,
  output logic              load_req,
  output cnt_t              load_val,
  output logic [DATA_W-1:0] rdata
);
  logic wr_ctrl, wr_inc, wr_per, wr_cper;

  assign wr_ctrl     = wr && (addr == A_CTRL);
  assign wr_inc      = wr && (addr == A_INC);
  assign wr_per      = wr && (addr == A_PERIOD);
  assign wr_cper     = wr && (addr == A_CPER);
  assign load_req    = wr && (addr == A_TIME);
  assign restart_req = wr_ctrl && wdata[B_RST];
  assign capture_req = wr_ctrl && wdata[B_CAP];
  assign load_val    = wdata[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg.en    <= wdata[B_EN];
        cfg.fold  <= wdata[B_FOLD];
        cfg.slave <= wdata[B_SLV];
      end
      if (wr_inc) begin
        cfg.inc  <= wdata[INC_LO +: INC_W];
        cfg.cinc <= wdata[CINC_LO +: INC_W];
      end
      if (wr_per)  cfg.period <= wdata[CNT_W-1:0];
      if (wr_cper) cfg.cper   <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[B_EN]   = cfg.en;
        rdata[B_FOLD] = cfg.fold;
        rdata[B_SLV]  = cfg.slave;
      end
      A_TIME:   rdata[CNT_W-1:0] = snapshot;
      A_PERIOD: rdata[CNT_W-1:0] = cfg.period;
      A_CPER:   rdata[CNT_W-1:0] = cfg.cper;
      A_INC: begin
        rdata[INC_LO +: INC_W]  = cfg.inc;
        rdata[CINC_LO +: INC_W] = cfg.cinc;
      end
      default: rdata = '0;
    endcase
  end

  // R7: a restart request never survives as a stored control bit
  a_r7_no_sticky_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (rdata[B_RST] == 1'b0 || addr != A_CTRL));
endmodule

// File: rtl/ptp_tc_corr.sv
module ptp_tc_corr
  import ptp_tc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  input  cnt_t cper,
  output logic use_corr
);
  cnt_t phase;

  assign use_corr = corr_due(phase, cper);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (clear) begin
      phase <= '0;
    end else if (tick) begin
      if (cper == '0 || use_corr) phase <= '0;
      else                        phase <= phase + 1'b1;
    end
  end

  // R3: after a correction step a window longer than one cycle starts over
  a_r3_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (use_corr && tick && !clear && cper > 1) |=> (!$stable(cper) || !use_corr));

  // R3: a zero correction period never selects the alternate increment
  a_r3_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cper == '0) |-> !use_corr);
endmodule

// File: rtl/ptp_tc_core.sv
module ptp_tc_core
  import ptp_tc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  input  logic use_corr,
  input  logic restart,
  input  logic load,
  input  cnt_t load_val,
  input  logic capture,
  output logic tick,
  output cnt_t count,
  output cnt_t snapshot,
  output logic wrap_pulse
);
  step_t stp;
  logic  unused_cfg;

  assign unused_cfg = cfg.slave ^ (^cfg.cper);
  assign tick = cfg.en && !restart && !load;

  always_comb begin
    stp = advance(count, use_corr ? cfg.cinc : cfg.inc, cfg.fold, cfg.period);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= '0;
      snapshot   <= '0;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= 1'b0;
      if (restart) begin
        count <= '0;
      end else if (load) begin
        count <= load_val;
      end else if (cfg.en) begin
        count      <= stp.val;
        wrap_pulse <= stp.wrapped;
      end
      if (capture) snapshot <= count;
    end
  end

  // R2: with counting off and no write, the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.en && !restart && !load) |=> $stable(count));

  // R4: a wrap pulse only follows a cycle with folding on and a period set
  a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> ($past(cfg.fold) && $past(cfg.period) != '0));

  // R4: the pulse is a single cycle when the count stays below the period
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_pulse && cfg.en && !restart && !load && cfg.inc < cfg.period &&
     cfg.cinc < cfg.period && count + cfg.period > count && count < cfg.period &&
     count + cfg.inc < cfg.period && count + cfg.cinc < cfg.period) |=> !wrap_pulse);

  // R5: the snapshot takes the count from before the capture edge
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> snapshot == $past(count));

  // R6: a load wins over counting
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !restart) |=> count == $past(load_val));

  // R7: restart clears the count
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> count == '0);
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CNT_W-1:0]  time_now,
  output logic              wrap_pulse
);
  cfg_t cfg;
  logic restart_req, capture_req, load_req, tick, use_corr;
  cnt_t load_val, snapshot, count;

  ptp_tc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .snapshot(snapshot), .cfg(cfg), .restart_req(restart_req),
    .capture_req(capture_req), .load_req(load_req), .load_val(load_val),
    .rdata(reg_rdata)
  );

  ptp_tc_corr u_corr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(restart_req),
    .cper(cfg.cper), .use_corr(use_corr)
  );

  ptp_tc_core u_core (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .use_corr(use_corr),
    .restart(restart_req), .load(load_req), .load_val(load_val),
    .capture(capture_req), .tick(tick), .count(count), .snapshot(snapshot),
    .wrap_pulse(wrap_pulse)
  );

  assign time_now = count;

  // R1: the first cycle out of reset shows a zero count and no pulse
  a_r1_reset_clean: assert property (@(posedge clk)
    $rose(rst_n) |-> (time_now == '0 && !wrap_pulse));
endmodule

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] time_now;
  logic        wrap_pulse;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R2";
  bit model_on = 1'b0;

  longint m_cnt, m_snap, m_per, m_cper, m_phase;
  int     m_inc, m_cinc;
  bit     m_en, m_fold, m_slv, m_wrap;

  ptp_time_counter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_now(time_now),
    .wrap_pulse(wrap_pulse)
  );

  always #2 clk = ~clk;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit due(longint phase, longint cper);
    return (cper != 0) && (phase + 1 >= cper);
  endfunction

  // Bench model of one edge, written from the requirements.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_snap = 0; m_per = 0; m_cper = 0; m_phase = 0;
      m_inc = 0; m_cinc = 0; m_en = 0; m_fold = 0; m_slv = 0; m_wrap = 0;
    end else begin
      longint old, add;
      bit is_ctrl;
      old = m_cnt;
      m_wrap = 0;
      is_ctrl = reg_wr && reg_addr == 12'h400;
      if (is_ctrl && reg_wdata[9]) begin
        m_cnt = 0; m_phase = 0;
      end else if (reg_wr && reg_addr == 12'h404) begin
        m_cnt = reg_wdata;
      end else if (m_en) begin
        if (due(m_phase, m_cper)) begin add = m_cinc; m_phase = 0; end
        else begin add = m_inc; m_phase = (m_cper == 0) ? 0 : m_phase + 1; end
        m_cnt = m_cnt + add;
        if (m_fold && m_per != 0 && m_cnt >= m_per) begin
          m_cnt = m_cnt - m_per; m_wrap = 1;
        end
        m_cnt = m_cnt & 64'hFFFF_FFFF;
      end
      if (is_ctrl && reg_wdata[11]) m_snap = old;
      if (is_ctrl) begin m_en = reg_wdata[0]; m_fold = reg_wdata[4]; m_slv = reg_wdata[13]; end
      if (reg_wr && reg_addr == 12'h414) begin m_inc = reg_wdata[6:0]; m_cinc = reg_wdata[14:8]; end
      if (reg_wr && reg_addr == 12'h40C) m_per = reg_wdata;
      if (reg_wr && reg_addr == 12'h410) m_cper = reg_wdata;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk(time_now == m_cnt[31:0], cur_req, "time_now", time_now, m_cnt);
      chk(wrap_pulse == m_wrap, "R4", "wrap_pulse", wrap_pulse, m_wrap);
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic longint exp_rd(logic [11:0] a);
    case (a)
      12'h400: return (longint'(m_slv) << 13) | (longint'(m_fold) << 4) | longint'(m_en);
      12'h404: return m_snap;
      12'h40C: return m_per;
      12'h410: return m_cper;
      12'h414: return (longint'(m_cinc) << 8) | longint'(m_inc);
      default: return 0;
    endcase
  endfunction

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] t0;
    int unsigned seed_init;
    seed_init = $urandom(32'h1588);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    model_on = 1'b1;

    // R1: reset state
    cur_req = "R1";
    rd(12'h404, d); chk(d == 0, "R1", "snapshot", d, 0);
    rd(12'h400, d); chk(d == 0, "R1", "control", d, 0);
    rd(12'h414, d); chk(d == 0, "R1", "increment", d, 0);
    chk(time_now == 0 && !wrap_pulse, "R1", "count/pulse", time_now, 0);

    // R8 / R7: readback and self-clearing bits
    cur_req = "R8";
    wr(12'h414, 32'h0000_0604);
    rd(12'h414, d); chk(d == 32'h0604, "R8", "inc readback", d, 32'h0604);
    wr(12'h400, 32'h0000_2010);
    rd(12'h400, d); chk(d == 32'h2010, "R8", "ctrl readback", d, 32'h2010);
    wr(12'h400, 32'h0000_2A10);
    rd(12'h400, d); chk(d == 32'h2010, "R7", "restart/capture bits read 0", d, 32'h2010);

    // R3: window of three, increments 4,4,6
    cur_req = "R3";
    wr(12'h410, 32'd3);
    wr(12'h400, 32'h0000_0001);
    chk(time_now == 0, "R2", "enable edge uses old enable", time_now, 0);
    step(3); chk(time_now == 14, "R3", "after 3 cycles", time_now, 14);
    step(3); chk(time_now == 28, "R3", "after 6 cycles", time_now, 28);

    // R4: fold with carry
    cur_req = "R4";
    wr(12'h400, 32'h0);
    t0 = time_now;
    step(2); chk(time_now == t0, "R2", "hold while disabled", time_now, t0);
    wr(12'h410, 32'd0);
    wr(12'h414, 32'h0000_000A);
    wr(12'h40C, 32'd100);
    wr(12'h404, 32'd95);
    wr(12'h400, 32'h0000_0011);
    chk(time_now == 95, "R6", "loaded value", time_now, 95);
    step(1); chk(time_now == 5 && wrap_pulse, "R4", "fold carry", time_now, 5);
    step(1); chk(time_now == 15 && !wrap_pulse, "R4", "pulse one cycle", time_now, 15);

    // R5: capture
    cur_req = "R5";
    wr(12'h400, 32'h0000_0811);
    rd(12'h404, d); chk(d == m_snap[31:0], "R5", "snapshot read", d, m_snap);

    // R6: load while counting
    cur_req = "R6";
    wr(12'h404, 32'd50);
    chk(time_now == 50, "R6", "load beats count", time_now, 50);

    // R7: restart with settings kept
    cur_req = "R7";
    wr(12'h400, 32'h0000_0211);
    chk(time_now == 0, "R7", "restart clears", time_now, 0);
    rd(12'h40C, d); chk(d == 100, "R7", "period kept", d, 100);
    rd(12'h414, d); chk(d == 32'h000A, "R7", "increment kept", d, 32'h000A);

    // R3: correction every cycle
    cur_req = "R3";
    wr(12'h414, 32'h0000_030A);
    wr(12'h410, 32'd1);
    t0 = time_now;
    step(1); chk(time_now == (t0 + 3) % 100, "R3", "N=1 corrects", time_now, (t0 + 3) % 100);

    // R4: full-width wrap without pulse
    cur_req = "R4";
    wr(12'h410, 32'd0);
    wr(12'h400, 32'h0000_0001);
    wr(12'h404, 32'hFFFF_FFF8);
    chk(time_now == 32'hFFFF_FFF8, "R6", "load near top", time_now, 32'hFFFF_FFF8);
    step(1); chk(time_now == 2 && !wrap_pulse, "R4", "natural wrap", time_now, 2);

    // Random traffic checked against the model every cycle
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 15);
      case (op)
        0: wr(12'h400, ($urandom_range(0, 7) != 0 ? 32'h1 : 32'h0) |
                       ($urandom_range(0, 1) << 4) | ($urandom_range(0, 1) << 13) |
                       ($urandom_range(0, 7) == 0 ? 32'h200 : 32'h0) |
                       ($urandom_range(0, 3) == 0 ? 32'h800 : 32'h0));
        1: wr(12'h414, ($urandom_range(0, 127) << 8) | $urandom_range(1, 127));
        2: wr(12'h40C, $urandom_range(0, 3) == 0 ? 32'd0 : $urandom_range(200, 3000));
        3: wr(12'h410, $urandom_range(0, 5));
        4: wr(12'h404, $urandom_range(0, 1) == 0 ? $urandom_range(0, 150) : $urandom);
        5, 6, 7, 8: begin
          logic [11:0] a;
          case ($urandom_range(0, 4))
            0: a = 12'h400; 1: a = 12'h404; 2: a = 12'h40C; 3: a = 12'h410; default: a = 12'h414;
          endcase
          rd(a, d);
          chk(d == exp_rd(a)[31:0], a == 12'h404 ? "R5" : "R8", "read", d, exp_rd(a));
        end
        default: step(1);
      endcase
    end

    step(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule